// File: doc/BRIEF.md
# Vertical Bus Lane Swapper

This block sits on the vertical bus between a memory controller and a stack of memory dies. Commands leave the controller as one flat set of lanes, with address lanes and data lanes side by side. Later, read data comes back up the data lanes. A small fault table, loaded by a self-test engine, names lanes known to be broken. Each table slot owns one standby lane that is fixed at design time. When a slot is armed, the broken lane's bit is carried on that slot's standby lane, and the broken lane itself is driven low.

The standby lanes are not idle spares. They are the top data lanes, and they carry real data whenever no fault needs them. So that nothing is lost when a standby lane is taken over, every write also copies the standby lanes' own data bits onto a side channel that goes to ECC storage. On a read, the block rebuilds the word in two steps. The standby position is restored from the side channel. If the broken lane was a data lane, its bit is taken from the standby lane. A broken address lane can be covered the same way, because the standby lanes carry the command's address bit on both reads and writes.

Table writes go to a shadow copy. The shadow is moved into the working table only on a cycle in which the controller reports no transfer in flight, so a burst never sees the mapping change partway through.

Top module: `tsv_lane_swapper`

## Requirements
- R1: Lane numbering is global. Lane g below ADDR_LANES is `cmd_addr[g]`, and any other lane g is `cmd_wdata[g-ADDR_LANES]`. With no slot armed, `phy_lanes` one cycle after a command equals `{cmd_wdata, cmd_addr}` for a write and `{0, cmd_addr}` for a read. `rd_data` one cycle after `phy_rd_valid` equals `phy_rd_data`.
- R2: Slot k's standby lane is global lane TOTAL-1-k, which is data bit DATA_LANES-1-k. While slot k is armed for lane f, `phy_lanes[TOTAL-1-k]` carries the command bit of lane f and `phy_lanes[f]` is 0.
- R3: On every write command, `ecc_side_wr[k]` one cycle later equals `cmd_wdata[DATA_LANES-1-k]`, whether or not any slot is armed. It is 0 after a read command.
- R4: On a read return with slot k armed for a data lane f, `rd_data[DATA_LANES-1-k]` equals `ecc_side_rd[k]` and `rd_data[f-ADDR_LANES]` equals `phy_rd_data[DATA_LANES-1-k]`. All other bits pass through unchanged.
- R5: A slot armed for an address lane restores its standby bit from `ecc_side_rd[k]` on reads and changes no other read bit. It also carries the address bit on the standby lane for read commands as well as write commands.
- R6: `phy_valid` follows `cmd_valid` and `rd_valid` follows `phy_rd_valid`, each one cycle later. When the matching valid is low, `phy_lanes`, `ecc_side_wr` and `rd_data` are 0.
- R7: A table write (`cfg_we`, `cfg_slot`, `cfg_valid`, `cfg_lane`) takes effect on the second rising edge after it is captured, provided `xfer_busy` is low at that edge. While `xfer_busy` is high the working table holds.
- R8: If two valid slots name the same lane, only the lower-numbered slot is armed and `map_err` is 1.
- R9: A valid slot whose lane is a standby lane (TOTAL-SPARE_SLOTS or above) or does not exist (TOTAL or above) is ignored, and `map_err` is 1.
- R10: After reset no slot is armed, `map_err`, `phy_valid` and `rd_valid` are 0, and `phy_lanes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one fault-table slot (shadow copy) |
| cfg_slot | input | SLOT_W | Slot being written |
| cfg_valid | input | 1 | Arm bit for the slot |
| cfg_lane | input | LANE_W | Global index of the broken lane |
| xfer_busy | input | 1 | Transfer in flight; shadow is not committed |
| map_err | output | 1 | Some valid slot is duplicated or illegal |
| cmd_valid | input | 1 | Command beat present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_LANES | Command address bits |
| cmd_wdata | input | DATA_LANES | Write data bits |
| phy_valid | output | 1 | Lanes toward the dies are valid |
| phy_lanes | output | TOTAL | Remapped lanes toward the dies |
| ecc_side_wr | output | SPARE_SLOTS | Standby-lane data copied to ECC storage |
| phy_rd_valid | input | 1 | Read beat arriving from the dies |
| phy_rd_data | input | DATA_LANES | Raw read data lanes |
| ecc_side_rd | input | SPARE_SLOTS | Standby-lane data read back from ECC storage |
| rd_valid | output | 1 | Rebuilt read data valid |
| rd_data | output | DATA_LANES | Rebuilt read data |

## Verification
The bench goes after slots whose broken lane is an address lane. A design that rebuilt those as data lanes would overwrite an unrelated read bit. It loads duplicate entries: if priority were reversed or both slots applied, the standby lane of the higher slot would stop carrying its own data. It names standby lanes and lanes that do not exist as faulty; a design that accepted them would fold a lane onto itself or index past the bus. It changes the table with `xfer_busy` high; a design that committed at once would remap the beats of the open burst. Random tables and beats, checked against bench-side models, cover the side-channel copy on reads and writes and the zero outputs on idle cycles.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    // Index width for a set of n items (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Global lane that serves as standby for a given slot.
    function automatic int standby_lane(input int total, input int slot);
        return total - 1 - slot;
    endfunction

endpackage

// File: rtl/lsw_fault_table.sv
module lsw_fault_table #(
    parameter int TOTAL  = 24,
    parameter int SLOTS  = 2,
    parameter int LANE_W = 5,
    parameter int SLOT_W = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SLOT_W-1:0]             cfg_slot,
    input  logic                          cfg_valid,
    input  logic [LANE_W-1:0]             cfg_lane,
    input  logic                          xfer_busy,
    output logic [SLOTS-1:0]              slot_en,
    output logic [SLOTS-1:0][LANE_W-1:0]  slot_lane,
    output logic                          map_err
);

    localparam int FIRST_STANDBY = TOTAL - SLOTS;

    typedef struct packed {
        logic              vld;
        logic [LANE_W-1:0] lane;
    } entry_t;

    typedef struct packed {
        entry_t [SLOTS-1:0] shadow;
        entry_t [SLOTS-1:0] active;
    } table_t;

    table_t tbl_d, tbl_q;
    logic [SLOTS-1:0] legal;
    logic [SLOTS-1:0] dup;

    always_comb begin
        tbl_d = tbl_q;
        if (cfg_we && (int'(cfg_slot) < SLOTS)) begin
            tbl_d.shadow[cfg_slot].vld  = cfg_valid;
            tbl_d.shadow[cfg_slot].lane = cfg_lane;
        end
        if (!xfer_busy) begin
            tbl_d.active = tbl_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    always_comb begin
        legal = '0;
        dup   = '0;
        for (int k = 0; k < SLOTS; k++) begin
            legal[k] = tbl_q.active[k].vld &&
                       (int'(tbl_q.active[k].lane) < FIRST_STANDBY);
        end
        for (int k = 1; k < SLOTS; k++) begin
            for (int j = 0; j < k; j++) begin
                if (legal[j] && (tbl_q.active[j].lane == tbl_q.active[k].lane)) begin
                    dup[k] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        map_err = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            slot_en[k]   = legal[k] && !dup[k];
            slot_lane[k] = tbl_q.active[k].lane;
            if (tbl_q.active[k].vld && !slot_en[k]) begin
                map_err = 1'b1;
            end
        end
    end

    // Working table must hold across a busy cycle.
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> (slot_en == $past(slot_en)) && (slot_lane == $past(slot_lane)));

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_chk
            p_legal_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
                slot_en[g] |-> (int'(slot_lane[g]) < FIRST_STANDBY));
            for (genvar h = g + 1; h < SLOTS; h++) begin : g_pair
                p_unique_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    !(slot_en[g] && slot_en[h] && (slot_lane[g] == slot_lane[h])));
            end
        end
    endgenerate

endmodule

// File: rtl/lsw_lane_mux.sv
module lsw_lane_mux #(
    parameter int ADDR_LANES = 8,
    parameter int DATA_LANES = 16,
    parameter int SLOTS      = 2,
    parameter int LANE_W     = 5
) (
    input  logic [SLOTS-1:0]                        slot_en,
    input  logic [SLOTS-1:0][LANE_W-1:0]            slot_lane,
    input  logic [ADDR_LANES+DATA_LANES-1:0]        cmd_lanes,
    output logic [ADDR_LANES+DATA_LANES-1:0]        tx_lanes,
    output logic [SLOTS-1:0]                        side_wr,
    input  logic [DATA_LANES-1:0]                   rd_lanes,
    input  logic [SLOTS-1:0]                        side_rd,
    output logic [DATA_LANES-1:0]                   rx_data
);

    localparam int TOTAL  = ADDR_LANES + DATA_LANES;
    localparam int DIDX_W = lsw_pkg::idx_width(DATA_LANES);

    logic [SLOTS-1:0]              is_data;
    logic [SLOTS-1:0][DIDX_W-1:0]  didx;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            assign is_data[g] = (int'(slot_lane[g]) >= ADDR_LANES);
            assign didx[g]    = DIDX_W'(int'(slot_lane[g]) - ADDR_LANES);
            assign side_wr[g] = cmd_lanes[lsw_pkg::standby_lane(TOTAL, g)];
        end
    endgenerate

    // Outbound: broken lane's bit rides the standby lane; broken lane goes quiet.
    always_comb begin
        tx_lanes = cmd_lanes;
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_en[k]) begin
                tx_lanes[lsw_pkg::standby_lane(TOTAL, k)] = cmd_lanes[slot_lane[k]];
            end
        end
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_en[k]) begin
                tx_lanes[slot_lane[k]] = 1'b0;
            end
        end
    end

    // Inbound: standby position restored from the side channel.
    always_comb begin
        rx_data = rd_lanes;
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_en[k]) begin
                rx_data[DATA_LANES-1-k] = side_rd[k];
                if (is_data[k]) begin
                    rx_data[didx[k]] = rd_lanes[DATA_LANES-1-k];
                end
            end
        end
    end

endmodule

// File: rtl/tsv_lane_swapper.sv
module tsv_lane_swapper #(
    parameter int ADDR_LANES  = 8,
    parameter int DATA_LANES  = 16,
    parameter int SPARE_SLOTS = 2,
    localparam int TOTAL  = ADDR_LANES + DATA_LANES,
    localparam int LANE_W = lsw_pkg::idx_width(TOTAL),
    localparam int SLOT_W = lsw_pkg::idx_width(SPARE_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [SLOT_W-1:0]      cfg_slot,
    input  logic                   cfg_valid,
    input  logic [LANE_W-1:0]      cfg_lane,
    input  logic                   xfer_busy,
    output logic                   map_err,
    input  logic                   cmd_valid,
    input  logic                   cmd_write,
    input  logic [ADDR_LANES-1:0]  cmd_addr,
    input  logic [DATA_LANES-1:0]  cmd_wdata,
    output logic                   phy_valid,
    output logic [TOTAL-1:0]       phy_lanes,
    output logic [SPARE_SLOTS-1:0] ecc_side_wr,
    input  logic                   phy_rd_valid,
    input  logic [DATA_LANES-1:0]  phy_rd_data,
    input  logic [SPARE_SLOTS-1:0] ecc_side_rd,
    output logic                   rd_valid,
    output logic [DATA_LANES-1:0]  rd_data
);

    typedef struct packed {
        logic                   tx_vld;
        logic [TOTAL-1:0]       tx_lanes;
        logic [SPARE_SLOTS-1:0] side;
        logic                   rx_vld;
        logic [DATA_LANES-1:0]  rx;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [SPARE_SLOTS-1:0]             slot_en;
    logic [SPARE_SLOTS-1:0][LANE_W-1:0] slot_lane;
    logic [TOTAL-1:0]                   cmd_lanes;
    logic [TOTAL-1:0]                   mux_tx;
    logic [SPARE_SLOTS-1:0]             mux_side;
    logic [DATA_LANES-1:0]              mux_rx;

    assign cmd_lanes = {(cmd_write ? cmd_wdata : {DATA_LANES{1'b0}}), cmd_addr};

    lsw_fault_table #(
        .TOTAL  (TOTAL),
        .SLOTS  (SPARE_SLOTS),
        .LANE_W (LANE_W),
        .SLOT_W (SLOT_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_slot  (cfg_slot),
        .cfg_valid (cfg_valid),
        .cfg_lane  (cfg_lane),
        .xfer_busy (xfer_busy),
        .slot_en   (slot_en),
        .slot_lane (slot_lane),
        .map_err   (map_err)
    );

    lsw_lane_mux #(
        .ADDR_LANES (ADDR_LANES),
        .DATA_LANES (DATA_LANES),
        .SLOTS      (SPARE_SLOTS),
        .LANE_W     (LANE_W)
    ) u_mux (
        .slot_en   (slot_en),
        .slot_lane (slot_lane),
        .cmd_lanes (cmd_lanes),
        .tx_lanes  (mux_tx),
        .side_wr   (mux_side),
        .rd_lanes  (phy_rd_data),
        .side_rd   (ecc_side_rd),
        .rx_data   (mux_rx)
    );

    always_comb begin
        pipe_d          = '0;
        pipe_d.tx_vld   = cmd_valid;
        pipe_d.rx_vld   = phy_rd_valid;
        if (cmd_valid) begin
            pipe_d.tx_lanes = mux_tx;
            pipe_d.side     = mux_side;
        end
        if (phy_rd_valid) begin
            pipe_d.rx = mux_rx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign phy_valid   = pipe_q.tx_vld;
    assign phy_lanes   = pipe_q.tx_lanes;
    assign ecc_side_wr = pipe_q.side;
    assign rd_valid    = pipe_q.rx_vld;
    assign rd_data     = pipe_q.rx;

    p_cmd_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> phy_valid);
    p_cmd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!phy_valid && (phy_lanes == '0)));
    p_rd_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rd_valid |=> rd_valid);
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write && (slot_en == '0)) |=>
            (phy_lanes == $past({cmd_wdata, cmd_addr})));
    p_rd_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rd_valid && (slot_en == '0)) |=> (rd_data == $past(phy_rd_data)));

    generate
        for (genvar g = 0; g < SPARE_SLOTS; g++) begin : g_prop
            p_side_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && cmd_write) |=>
                    (ecc_side_wr[g] == $past(cmd_wdata[DATA_LANES-1-g])));
            p_standby_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && slot_en[g]) |=>
                    (phy_lanes[TOTAL-1-g] == $past(cmd_lanes[slot_lane[g]])));
            p_faulty_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && slot_en[g]) |=> (phy_lanes[$past(slot_lane[g])] == 1'b0));
            p_side_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (phy_rd_valid && slot_en[g]) |=>
                    (rd_data[DATA_LANES-1-g] == $past(ecc_side_rd[g])));
        end
    endgenerate

endmodule

// File: tb/tsv_lane_swapper_test.sv
`timescale 1ns/1ps
module tsv_lane_swapper_test;

    localparam int A  = 8;
    localparam int D  = 16;
    localparam int S  = 2;
    localparam int L  = A + D;
    localparam int LW = 5;
    localparam int SW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [SW-1:0] cfg_slot = '0;
    logic cfg_valid = 1'b0;
    logic [LW-1:0] cfg_lane = '0;
    logic xfer_busy = 1'b0;
    logic map_err;
    logic cmd_valid = 1'b0;
    logic cmd_write = 1'b0;
    logic [A-1:0] cmd_addr = '0;
    logic [D-1:0] cmd_wdata = '0;
    logic phy_valid;
    logic [L-1:0] phy_lanes;
    logic [S-1:0] ecc_side_wr;
    logic phy_rd_valid = 1'b0;
    logic [D-1:0] phy_rd_data = '0;
    logic [S-1:0] ecc_side_rd = '0;
    logic rd_valid;
    logic [D-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic          sh_v [S];
    logic [LW-1:0] sh_l [S];
    logic          ac_v [S];
    logic [LW-1:0] ac_l [S];

    always #5 clk = ~clk;

    tsv_lane_swapper uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_valid(cfg_valid), .cfg_lane(cfg_lane), .xfer_busy(xfer_busy),
        .map_err(map_err), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .phy_valid(phy_valid),
        .phy_lanes(phy_lanes), .ecc_side_wr(ecc_side_wr),
        .phy_rd_valid(phy_rd_valid), .phy_rd_data(phy_rd_data),
        .ecc_side_rd(ecc_side_rd), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R8/R9 model: which slots are armed.
    function automatic logic [S-1:0] m_en();
        logic [S-1:0] lg, en;
        for (int k = 0; k < S; k++) lg[k] = ac_v[k] && (int'(ac_l[k]) < L - S);
        for (int k = 0; k < S; k++) begin
            en[k] = lg[k];
            for (int j = 0; j < k; j++)
                if (lg[j] && ac_l[j] == ac_l[k]) en[k] = 1'b0;
        end
        return en;
    endfunction

    function automatic logic m_err();
        logic [S-1:0] en = m_en();
        for (int k = 0; k < S; k++) if (ac_v[k] && !en[k]) return 1'b1;
        return 1'b0;
    endfunction

    // R1/R2/R5 model of the outbound lanes.
    function automatic logic [L-1:0] m_tx(input logic w, input logic [A-1:0] a, input logic [D-1:0] wd);
        logic [L-1:0] base = {(w ? wd : {D{1'b0}}), a};
        logic [L-1:0] t = base;
        logic [S-1:0] en = m_en();
        for (int k = 0; k < S; k++) if (en[k]) t[L-1-k] = base[ac_l[k]];
        for (int k = 0; k < S; k++) if (en[k]) t[ac_l[k]] = 1'b0;
        return t;
    endfunction

    // R4/R5 model of rebuilt read data.
    function automatic logic [D-1:0] m_rx(input logic [D-1:0] rd, input logic [S-1:0] sd);
        logic [D-1:0] r = rd;
        logic [S-1:0] en = m_en();
        for (int k = 0; k < S; k++) if (en[k]) begin
            r[D-1-k] = sd[k];
            if (int'(ac_l[k]) >= A) r[int'(ac_l[k]) - A] = rd[D-1-k];
        end
        return r;
    endfunction

    function automatic logic [S-1:0] m_side(input logic w, input logic [D-1:0] wd);
        logic [S-1:0] s = '0;
        for (int k = 0; k < S; k++) s[k] = w ? wd[D-1-k] : 1'b0;
        return s;
    endfunction

    // Called at a negedge; writes the shadow copy.
    task automatic cfg(input int slot, input logic v, input logic [LW-1:0] lane);
        cfg_we = 1'b1; cfg_slot = SW'(slot); cfg_valid = v; cfg_lane = lane;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_v[slot] = v; sh_l[slot] = lane;
    endtask

    // Called at a negedge with xfer_busy low: waits for the commit edge.
    task automatic commit();
        @(negedge clk);
        for (int k = 0; k < S; k++) begin ac_v[k] = sh_v[k]; ac_l[k] = sh_l[k]; end
    endtask

    // One command beat plus one read return, checked one cycle later.
    task automatic beat(input string req, input logic cv, input logic w, input logic [A-1:0] a,
                        input logic [D-1:0] wd, input logic rv, input logic [D-1:0] rd,
                        input logic [S-1:0] sd);
        logic [L-1:0] etx;
        logic [S-1:0] esd;
        logic [D-1:0] erx;
        cmd_valid = cv; cmd_write = w; cmd_addr = a; cmd_wdata = wd;
        phy_rd_valid = rv; phy_rd_data = rd; ecc_side_rd = sd;
        etx = cv ? m_tx(w, a, wd) : '0;
        esd = cv ? m_side(w, wd) : '0;
        erx = rv ? m_rx(rd, sd) : '0;
        @(negedge clk);
        check({req, " phy_valid R6"}, 64'(phy_valid), 64'(cv));
        check({req, " phy_lanes"}, 64'(phy_lanes), 64'(etx));
        check({req, " ecc_side_wr R3"}, 64'(ecc_side_wr), 64'(esd));
        check({req, " rd_valid R6"}, 64'(rd_valid), 64'(rv));
        check({req, " rd_data"}, 64'(rd_data), 64'(erx));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int k = 0; k < S; k++) begin sh_v[k] = 0; sh_l[k] = 0; ac_v[k] = 0; ac_l[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 phy_valid", 64'(phy_valid), 0);
        check("R10 rd_valid", 64'(rd_valid), 0);
        check("R10 map_err", 64'(map_err), 0);
        check("R10 phy_lanes", 64'(phy_lanes), 0);

        // R1 pass-through, write and read
        beat("R1 write", 1, 1, 8'hA5, 16'hC3F0, 1, 16'h1234, 2'b01);
        beat("R1 read", 1, 0, 8'h5A, 16'hFFFF, 0, 16'h0, 2'b00);
        beat("R6 idle", 0, 0, 8'hFF, 16'hFFFF, 0, 16'hFFFF, 2'b11);

        // R2/R4: slot0 -> data lane 13 (wdata bit 5); R5: slot1 -> address lane 2
        cfg(0, 1, 5'd13);
        cfg(1, 1, 5'd2);
        commit();
        check("R8 map_err clean", 64'(map_err), 0);
        beat("R2 write swap", 1, 1, 8'h04, 16'h0020, 1, 16'h8000, 2'b10);
        beat("R5 read cmd addr swap", 1, 0, 8'hFB, 16'hFFFF, 1, 16'h4000, 2'b01);
        beat("R4 data rebuild", 1, 1, 8'h00, 16'hFFDF, 1, 16'h7FFF, 2'b11);
        check("R4 direct bit", 64'(rd_data[5]), 64'(0));

        // R7: change while busy holds the old map
        xfer_busy = 1'b1;
        cfg(0, 1, 5'd7);
        beat("R7 held", 1, 1, 8'h80, 16'h0020, 1, 16'h8000, 2'b00);
        beat("R7 held2", 1, 1, 8'h80, 16'h0020, 0, 16'h0, 2'b00);
        check("R7 standby still old", 64'(phy_lanes[L-1]), 64'(1));
        xfer_busy = 1'b0;
        commit();
        beat("R7 applied", 1, 1, 8'h80, 16'h0000, 0, 16'h0, 2'b00);
        check("R7 standby new", 64'(phy_lanes[L-1]), 64'(1));

        // R8 duplicate: lower slot wins
        cfg(0, 1, 5'd13);
        cfg(1, 1, 5'd13);
        commit();
        check("R8 map_err dup", 64'(map_err), 1);
        beat("R8 dup", 1, 1, 8'h00, 16'h6020, 1, 16'h0, 2'b11);
        check("R8 slot1 standby own bit", 64'(phy_lanes[L-2]), 64'(1));

        // R9 standby lane and nonexistent lane ignored
        cfg(0, 1, 5'd22);
        cfg(1, 1, 5'd27);
        commit();
        check("R9 map_err illegal", 64'(map_err), 1);
        beat("R9 ignored", 1, 1, 8'h3C, 16'hA55A, 1, 16'h0FF0, 2'b11);
        check("R9 passthru", 64'(phy_lanes), 64'({16'hA55A, 8'h3C}));

        // Random tables and beats
        for (int it = 0; it < 400; it++) begin
            if (it % 25 == 0) begin
                for (int k = 0; k < S; k++) begin
                    logic [LW-1:0] ln;
                    ln = LW'($urandom_range(0, (it % 75 == 0) ? 31 : 21));
                    cfg(k, 1'($urandom_range(0, 3) != 0), ln);
                end
                commit();
                check("R8 R9 random map_err", 64'(map_err), 64'(m_err()));
            end
            beat("R1 R2 R4 R5 random", 1'($urandom_range(0, 3) != 0), 1'($urandom),
                 A'($urandom), D'($urandom), 1'($urandom), D'($urandom), S'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule